// File: doc/BRIEF.md
# Two-Wire Front-End Control Bus Slave Sequence Decoder

This block is the slave-side receiver of a two-wire front-end control bus made of a clock line and a bidirectional data line. It runs on a fast local clock and oversamples both lines. It finds the start condition of each sequence, shifts in the slave address, the command byte and the parity bits, and then decodes one of three basic sequences: a register write, a register read and a short write to register 0. Each accepted access reaches a simple register-file port as a one-cycle write or read strobe, together with an address and write data.

On a read addressed to this slave, the block captures the register-file data and returns it on the data line with a parity bit. It then finishes with a bus park cycle and releases the line. Every protocol violation sets its own sticky bit in an error vector, and the surrounding register file clears that vector. Extended sequences are recognised and rejected.

Top module: `rffeSlave`

## Requirements
- R1: A sequence begins only when the data line rises and then falls while the clock line is low. Bits are sampled on falling clock edges, MSB first. The first frame is the 4-bit slave address, then the 8-bit command, then one parity bit. A high-low pulse on the data line while the clock is high starts nothing, and no strobe follows it.
- R2: Command `010aaaaa` is a register write. It is followed by an 8-bit data frame and its parity bit. If the slave address equals `mySid`, equals `groupSid` or is 0 (broadcast), the block gives exactly one one-cycle `regWrite` with `regAddr`=aaaaa and `regWrData`=the data. Any other slave address is ignored.
- R3: Command `1ddddddd` is a register-0 write. It gives one `regWrite` with `regAddr`=0 and `regWrData`={0,ddddddd}. It is accepted for the same slave addresses as R2.
- R4: Command `011aaaaa` with slave address `mySid` is a read. It gives one `regRead` and captures `regRdData` one cycle later. After one park cycle, the block drives the 8 data bits MSB first, changing on rising clock edges, and then their odd parity bit. It then drives 0 through the next park cycle and drops `sdataOe` at that cycle's falling edge. `sdataOe` is high at no other time.
- R5: All parity bits are odd parity, so the frame plus its parity bit holds an odd number of ones. A command frame with bad parity is discarded and sets `errFlags[6]`.
- R6: A command whose top three bits are 000 or 001 (extended sequences) is discarded and sets `errFlags[5]`. A start condition that arrives before the current sequence has completed also sets `errFlags[5]`, and a new sequence then begins.
- R7: A write data frame with bad parity sets `errFlags[3]` and gives no strobe.
- R8: The parameter `IMPL_MASK` has bit n set when address n exists. A write to an address that does not exist sets `errFlags[1]` and gives no strobe. A read from such an address sets `errFlags[2]`, gives no `regRead`, and returns data 0x00 with parity 1.
- R9: A read addressed to 0 or to `groupSid`, but not to `mySid`, is not answered: `sdataOe` stays low and `errFlags[0]` is set.
- R10: The bits of `errFlags` are sticky. Only `errClr` or reset clears them, and a set in the same cycle as `errClr` wins. `errFlags[4]` (address-frame parity) stays 0 because basic sequences carry no address frame. `regWrite` and `regRead` are never high together. After reset, `sdataOe`=0 and `errFlags`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Bus clock line |
| sdataIn | input | 1 | Bus data line as seen at the pad |
| sdataOut | output | 1 | Data driven onto the bus |
| sdataOe | output | 1 | Drive enable for sdataOut |
| mySid | input | 4 | Own slave address |
| groupSid | input | 4 | Group slave address |
| regWrite | output | 1 | One-cycle register write strobe |
| regRead | output | 1 | One-cycle register read strobe |
| regAddr | output | 5 | Register address for either strobe |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register read data, valid the cycle after regRead |
| errClr | input | 1 | Clears all error flags |
| errFlags | output | 7 | Sticky error flags: 6 cmd parity, 5 length, 4 address parity, 3 data parity, 2 read unused, 1 write unused, 0 broadcast/group read |

## Verification
The bench walks a table of writes, reads and register-0 writes sent to the own, group, broadcast and foreign slave addresses, and to implemented and unimplemented registers. A decoder that compared the slave address wrongly would strobe on foreign traffic, or would answer a broadcast read by driving the line against other slaves. Directed cases send a bad command parity, a bad data parity, an extended command code and a write cut short by a new start. A design that skipped any of these checks would issue a write with corrupted data or lose the following sequence. Further cases send a high-low pulse while the clock is high, which a careless start detector would take as a start, and check that error flags pile up until they are cleared.

// File: rtl/rffeSlavePkg.sv
package rffeSlavePkg;
  localparam int SID_W    = 4;
  localparam int CMD_W    = 8;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 8;
  localparam int ERR_W    = 7;
  localparam int HEAD_W   = SID_W + 3;
  localparam int CMD_LEN  = SID_W + CMD_W;
  localparam int CNT_W    = $clog2(CMD_LEN + 1);
  localparam logic [SID_W-1:0] BCAST_SID = '0;

  localparam int ERR_CMD_PAR   = 6;
  localparam int ERR_LEN       = 5;
  localparam int ERR_ADDR_PAR  = 4;
  localparam int ERR_DATA_PAR  = 3;
  localparam int ERR_RD_UNUSED = 2;
  localparam int ERR_WR_UNUSED = 1;
  localparam int ERR_BC_READ   = 0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_CCHK, ST_WDATA, ST_WCHK, ST_WSTB,
    ST_RSTB, ST_RLOAD, ST_RPARK, ST_RDRIVE, ST_RREL
  } stateT;

  typedef struct packed {
    logic             shiftIn;
    logic             parIn;
    logic             clrFrame;
    logic             latchCmd;
    logic             loadData;
    logic             dataSel;
    logic             loadTx;
    logic             txZero;
    logic             shiftTx;
    logic             driveZero;
    logic             releaseBus;
    logic [ERR_W-1:0] setErr;
  } ctrlStrobeT;
endpackage

// File: rtl/rffeSlaveDatapath.sv
module rffeSlaveDatapath
  import rffeSlavePkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              sdataIn,
  input  logic              errClr,
  input  logic [DATA_W-1:0] regRdData,
  input  ctrlStrobeT        strb,
  output logic              sclkRise,
  output logic              sclkFall,
  output logic              startSeen,
  output logic [HEAD_W-1:0] frameHead,
  output logic              parOk,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              sdataOut,
  output logic              sdataOe,
  output logic [ERR_W-1:0]  errFlags
);
  localparam int FRAME_W = CMD_LEN;
  localparam int TX_W    = DATA_W + 1;

  logic [SYNC_STAGES-1:0] sclkSync, sdataSync;
  logic sclkS, sdataS, sclkPrev, sdataPrev, armed;
  logic sdataRise, sdataFall;
  logic [FRAME_W-1:0] frame;
  logic parAcc;
  logic [TX_W-1:0] txReg;
  logic [ERR_W-1:0] errReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;

  assign sclkS     = sclkSync[SYNC_STAGES-1];
  assign sdataS    = sdataSync[SYNC_STAGES-1];
  assign sclkRise  = sclkS & ~sclkPrev;
  assign sclkFall  = ~sclkS & sclkPrev;
  assign sdataRise = sdataS & ~sdataPrev;
  assign sdataFall = ~sdataS & sdataPrev;
  assign startSeen = armed & sdataFall & ~sclkS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSync  <= '0;
      sdataSync <= '0;
      sclkPrev  <= 1'b0;
      sdataPrev <= 1'b0;
      armed     <= 1'b0;
    end else begin
      sclkSync  <= {sclkSync[SYNC_STAGES-2:0], sclk};
      sdataSync <= {sdataSync[SYNC_STAGES-2:0], sdataIn};
      sclkPrev  <= sclkS;
      sdataPrev <= sdataS;
      if (sclkS || startSeen) armed <= 1'b0;
      else if (sdataRise)     armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frame  <= '0;
      parAcc <= 1'b0;
    end else if (strb.clrFrame) begin
      frame  <= '0;
      parAcc <= 1'b0;
    end else if (strb.shiftIn) begin
      frame  <= {frame[FRAME_W-2:0], sdataS};
      parAcc <= parAcc ^ sdataS;
    end else if (strb.parIn) begin
      parAcc <= parAcc ^ sdataS;
    end
  end

  assign frameHead = frame[FRAME_W-1 -: HEAD_W];
  assign parOk     = parAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strb.latchCmd)
        addrReg <= frame[CMD_W-1] ? '0 : frame[ADDR_W-1:0];
      if (strb.loadData)
        dataReg <= strb.dataSel ? {1'b0, frame[CMD_W-2:0]} : frame[DATA_W-1:0];
    end
  end

  assign regAddr   = addrReg;
  assign regWrData = dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg    <= '0;
      sdataOut <= 1'b0;
      sdataOe  <= 1'b0;
    end else if (strb.releaseBus) begin
      sdataOut <= 1'b0;
      sdataOe  <= 1'b0;
    end else if (strb.loadTx) begin
      txReg <= strb.txZero ? TX_W'(1) : {regRdData, ~^regRdData};
    end else if (strb.shiftTx) begin
      sdataOut <= txReg[TX_W-1];
      sdataOe  <= 1'b1;
      txReg    <= {txReg[TX_W-2:0], 1'b0};
    end else if (strb.driveZero) begin
      sdataOut <= 1'b0;
      sdataOe  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errReg <= '0;
    else       errReg <= (errClr ? '0 : errReg) | strb.setErr;
  end

  assign errFlags = errReg;
endmodule

// File: rtl/rffeSlaveCtrl.sv
module rffeSlaveCtrl
  import rffeSlavePkg::*;
#(
  parameter logic [31:0] IMPL_MASK = 32'hF000_0007
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic              startSeen,
  input  logic [HEAD_W-1:0] frameHead,
  input  logic              parOk,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [SID_W-1:0]  mySid,
  input  logic [SID_W-1:0]  groupSid,
  output ctrlStrobeT        strb,
  output logic              regWrite,
  output logic              regRead
);
  stateT state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;
  logic [SID_W-1:0] sa;
  logic [2:0] op;
  logic ownHit, shareHit, wrHit, implHit;

  assign sa       = frameHead[HEAD_W-1 -: SID_W];
  assign op       = frameHead[2:0];
  assign ownHit   = (sa == mySid);
  assign shareHit = (sa == BCAST_SID) || (sa == groupSid);
  assign wrHit    = ownHit || shareHit;
  assign implHit  = IMPL_MASK[regAddr];

  always_comb begin
    stateNxt  = state;
    bitCntNxt = bitCnt;
    strb      = '0;
    regWrite  = 1'b0;
    regRead   = 1'b0;
    case (state)
      ST_CMD: if (sclkFall) begin
        if (bitCnt == CNT_W'(CMD_LEN)) begin
          strb.parIn = 1'b1;
          bitCntNxt  = '0;
          stateNxt   = ST_CCHK;
        end else begin
          strb.shiftIn = 1'b1;
          bitCntNxt    = bitCnt + 1'b1;
        end
      end
      ST_CCHK: begin
        strb.latchCmd = 1'b1;
        stateNxt      = ST_IDLE;
        if (!parOk) strb.setErr[ERR_CMD_PAR] = 1'b1;
        else if (op[2]) begin
          if (wrHit) begin
            strb.loadData = 1'b1;
            strb.dataSel  = 1'b1;
            stateNxt      = ST_WSTB;
          end
        end else if (op == 3'b010) begin
          if (wrHit) begin
            strb.clrFrame = 1'b1;
            stateNxt      = ST_WDATA;
          end
        end else if (op == 3'b011) begin
          if (ownHit)        stateNxt = ST_RSTB;
          else if (shareHit) strb.setErr[ERR_BC_READ] = 1'b1;
        end else begin
          strb.setErr[ERR_LEN] = 1'b1;
        end
      end
      ST_WDATA: if (sclkFall) begin
        if (bitCnt == CNT_W'(DATA_W)) begin
          strb.parIn = 1'b1;
          bitCntNxt  = '0;
          stateNxt   = ST_WCHK;
        end else begin
          strb.shiftIn = 1'b1;
          bitCntNxt    = bitCnt + 1'b1;
        end
      end
      ST_WCHK: begin
        if (!parOk) begin
          strb.setErr[ERR_DATA_PAR] = 1'b1;
          stateNxt = ST_IDLE;
        end else begin
          strb.loadData = 1'b1;
          stateNxt      = ST_WSTB;
        end
      end
      ST_WSTB: begin
        if (implHit) regWrite = 1'b1;
        else         strb.setErr[ERR_WR_UNUSED] = 1'b1;
        stateNxt = ST_IDLE;
      end
      ST_RSTB: begin
        if (implHit) regRead = 1'b1;
        else         strb.setErr[ERR_RD_UNUSED] = 1'b1;
        stateNxt = ST_RLOAD;
      end
      ST_RLOAD: begin
        strb.loadTx = 1'b1;
        strb.txZero = !implHit;
        stateNxt    = ST_RPARK;
      end
      ST_RPARK: if (sclkFall) begin
        bitCntNxt = '0;
        stateNxt  = ST_RDRIVE;
      end
      ST_RDRIVE: if (sclkRise) begin
        if (bitCnt == CNT_W'(DATA_W + 1)) begin
          strb.driveZero = 1'b1;
          stateNxt       = ST_RREL;
        end else begin
          strb.shiftTx = 1'b1;
          bitCntNxt    = bitCnt + 1'b1;
        end
      end
      ST_RREL: if (sclkFall) begin
        strb.releaseBus = 1'b1;
        stateNxt        = ST_IDLE;
      end
      default: ;
    endcase
    if (startSeen) begin
      strb                 = '0;
      strb.setErr[ERR_LEN] = (state != ST_IDLE);
      strb.clrFrame        = 1'b1;
      strb.releaseBus      = 1'b1;
      regWrite             = 1'b0;
      regRead              = 1'b0;
      bitCntNxt            = '0;
      stateNxt             = ST_CMD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
    end
  end
endmodule

// File: rtl/rffeSlave.sv
module rffeSlave
  import rffeSlavePkg::*;
#(
  parameter logic [31:0] IMPL_MASK   = 32'hF000_0007,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              sdataIn,
  output logic              sdataOut,
  output logic              sdataOe,
  input  logic [SID_W-1:0]  mySid,
  input  logic [SID_W-1:0]  groupSid,
  output logic              regWrite,
  output logic              regRead,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData,
  input  logic              errClr,
  output logic [ERR_W-1:0]  errFlags
);
  ctrlStrobeT        strb;
  logic              sclkRise, sclkFall, startSeen, parOk;
  logic [HEAD_W-1:0] frameHead;

  rffeSlaveDatapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdataIn(sdataIn), .errClr(errClr),
    .regRdData(regRdData), .strb(strb), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .startSeen(startSeen), .frameHead(frameHead), .parOk(parOk),
    .regAddr(regAddr), .regWrData(regWrData), .sdataOut(sdataOut),
    .sdataOe(sdataOe), .errFlags(errFlags)
  );

  rffeSlaveCtrl #(.IMPL_MASK(IMPL_MASK)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .sclkFall(sclkFall),
    .startSeen(startSeen), .frameHead(frameHead), .parOk(parOk),
    .regAddr(regAddr), .mySid(mySid), .groupSid(groupSid), .strb(strb),
    .regWrite(regWrite), .regRead(regRead)
  );
endmodule

// File: rtl/rffeSlaveChk.sv
module rffeSlaveChk #(
  parameter logic [31:0] IMPL_MASK = 32'hF000_0007
) (
  input logic       clk,
  input logic       rstN,
  input logic       regWrite,
  input logic       regRead,
  input logic [4:0] regAddr,
  input logic       errClr,
  input logic [6:0] errFlags
);
  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrite && regRead));

  // R2
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |=> !regWrite);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !errClr |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  // R8
  write_impl_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrite |-> IMPL_MASK[regAddr]);

  // R8
  read_impl_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRead |-> IMPL_MASK[regAddr]);
endmodule

bind rffeSlave rffeSlaveChk #(.IMPL_MASK(IMPL_MASK)) i_chk (
  .clk(clk), .rstN(rstN), .regWrite(regWrite), .regRead(regRead),
  .regAddr(regAddr), .errClr(errClr), .errFlags(errFlags)
);

// File: tb/test_rffeSlave.sv
module test_rffeSlave;
  localparam int H = 8;
  localparam logic [3:0] MY = 4'h3;
  localparam logic [3:0] GRP = 4'h9;

  typedef struct packed {
    logic [1:0] kind;   // 0 write, 1 read, 2 register-0 write
    logic [3:0] sa;
    logic [4:0] addr;
    logic [7:0] data;
    logic       expWr;
    logic       expRd;
    logic       expDrive;
    logic [6:0] expErr;
  } vecT;

  localparam int NV = 12;
  localparam vecT VECS [NV] = '{
    '{2'd0, 4'h3, 5'h01, 8'hA5, 1'b1, 1'b0, 1'b0, 7'h00},
    '{2'd0, 4'h9, 5'h02, 8'h3C, 1'b1, 1'b0, 1'b0, 7'h00},
    '{2'd0, 4'h0, 5'h1C, 8'h81, 1'b1, 1'b0, 1'b0, 7'h00},
    '{2'd0, 4'h5, 5'h01, 8'h77, 1'b0, 1'b0, 1'b0, 7'h00},
    '{2'd0, 4'h3, 5'h05, 8'h12, 1'b0, 1'b0, 1'b0, 7'h02},
    '{2'd1, 4'h3, 5'h1D, 8'h00, 1'b0, 1'b1, 1'b1, 7'h00},
    '{2'd1, 4'h3, 5'h06, 8'h00, 1'b0, 1'b0, 1'b1, 7'h04},
    '{2'd1, 4'h0, 5'h01, 8'h00, 1'b0, 1'b0, 1'b0, 7'h01},
    '{2'd1, 4'h9, 5'h02, 8'h00, 1'b0, 1'b0, 1'b0, 7'h01},
    '{2'd2, 4'h3, 5'h00, 8'h55, 1'b1, 1'b0, 1'b0, 7'h00},
    '{2'd2, 4'h0, 5'h00, 8'h01, 1'b1, 1'b0, 1'b0, 7'h00},
    '{2'd1, 4'h5, 5'h1D, 8'h00, 1'b0, 1'b0, 1'b0, 7'h00}
  };

  logic clk = 0, rstN = 0, sclk = 0, mst = 0, errClr = 0;
  logic sdataOut, sdataOe, regWrite, regRead, line;
  logic [4:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [6:0] errFlags;
  int checks = 0, failures = 0, wrCount = 0, rdCount = 0;
  logic [4:0] lastAddr;
  logic [7:0] lastData;
  logic oeSeen = 0, done = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] rdModel(input logic [4:0] a);
    return {a, 3'b101} ^ 8'h3C;
  endfunction

  assign regRdData = rdModel(regAddr);
  assign line = sdataOe ? sdataOut : mst;

  rffeSlave i_rffeSlave (
    .clk(clk), .rstN(rstN), .sclk(sclk), .sdataIn(line), .sdataOut(sdataOut),
    .sdataOe(sdataOe), .mySid(MY), .groupSid(GRP), .regWrite(regWrite),
    .regRead(regRead), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .errClr(errClr), .errFlags(errFlags)
  );

  always @(negedge clk) begin
    if (regWrite) begin wrCount++; lastAddr = regAddr; lastData = regWrData; end
    if (regRead) rdCount++;
    if (sdataOe) oeSeen = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic halfWait(); repeat (H) @(negedge clk); endtask
  task automatic sendBit(input logic b); sclk = 1; mst = b; halfWait(); sclk = 0; halfWait(); endtask
  task automatic startCond(); mst = 0; halfWait(); mst = 1; halfWait(); mst = 0; halfWait(); endtask
  task automatic park(); sclk = 1; mst = 0; halfWait(); sclk = 0; halfWait(); endtask

  task automatic sendFrame(input logic [11:0] v, input int n, input logic badPar);
    logic p;
    p = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin sendBit(v[i]); p ^= v[i]; end
    sendBit(p ^ badPar);
  endtask

  task automatic readBits(output logic [8:0] v);
    v = '0;
    for (int i = 0; i < 9; i++) begin
      sclk = 1; mst = 0;
      repeat (H - 1) @(negedge clk);
      v = {v[7:0], line};
      @(negedge clk);
      sclk = 0; halfWait();
    end
  endtask

  task automatic clearErr(); errClr = 1; @(negedge clk); errClr = 0; @(negedge clk); endtask

  task automatic doWrite(input logic [3:0] sa, input logic [4:0] a, input logic [7:0] d,
                         input logic badCmd, input logic badData);
    startCond();
    sendFrame({sa, 3'b010, a}, 12, badCmd);
    sendFrame({4'h0, d}, 8, badData);
    park();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [8:0] rx;
    int w0, r0;
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (4) @(negedge clk);
    // R10 reset state, R4 bus not driven after reset
    chk("R10 reset errFlags", errFlags, 0);
    chk("R4 reset sdataOe", sdataOe, 0);
    chk("R10 reset strobes", wrCount + rdCount, 0);

    for (int v = 0; v < NV; v++) begin
      clearErr();
      w0 = wrCount; r0 = rdCount; oeSeen = 0; rx = '0;
      startCond();
      case (VECS[v].kind)
        2'd0: begin
          sendFrame({VECS[v].sa, 3'b010, VECS[v].addr}, 12, 1'b0);
          sendFrame({4'h0, VECS[v].data}, 8, 1'b0);
          park();
        end
        2'd1: begin
          sendFrame({VECS[v].sa, 3'b011, VECS[v].addr}, 12, 1'b0);
          park();
          readBits(rx);
          park();
        end
        default: begin
          sendFrame({VECS[v].sa, 1'b1, VECS[v].data[6:0]}, 12, 1'b0);
          park();
        end
      endcase
      repeat (4) @(negedge clk);
      // R2 R3 write strobes, R4 R8 R9 read path
      chk("R2 R3 write count", wrCount - w0, VECS[v].expWr);
      chk("R4 read count", rdCount - r0, VECS[v].expRd);
      chk("R4 R9 drive seen", oeSeen, VECS[v].expDrive);
      chk("R8 R9 errFlags", errFlags, VECS[v].expErr);
      chk("R4 released", sdataOe, 0);
      if (VECS[v].expWr) begin
        if (VECS[v].kind == 2'd2) begin
          chk("R3 reg0 addr", lastAddr, 0);
          chk("R3 reg0 data", lastData, {1'b0, VECS[v].data[6:0]});
        end else begin
          chk("R2 write addr", lastAddr, VECS[v].addr);
          chk("R2 write data", lastData, VECS[v].data);
        end
      end
      if (VECS[v].expDrive) begin
        if (VECS[v].expRd)
          chk("R4 read data+parity", rx, {rdModel(VECS[v].addr), ~^rdModel(VECS[v].addr)});
        else
          chk("R8 unused read data", rx, 9'h001);
      end
    end

    // R5 command parity error
    clearErr(); w0 = wrCount;
    doWrite(MY, 5'h01, 8'h11, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R5 cmd parity flag", errFlags, 7'h40);
    chk("R5 cmd parity no write", wrCount - w0, 0);

    // R6 extended command rejected
    clearErr(); w0 = wrCount;
    startCond();
    sendFrame({MY, 8'h05}, 12, 1'b0);
    park();
    repeat (4) @(negedge clk);
    chk("R6 extended flag", errFlags, 7'h20);
    chk("R6 extended no write", wrCount - w0, 0);

    // R6 truncated sequence followed by a good one
    clearErr(); w0 = wrCount;
    startCond();
    sendFrame({MY, 3'b010, 5'h01}, 12, 1'b0);
    doWrite(MY, 5'h02, 8'h5A, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R6 truncated flag", errFlags, 7'h20);
    chk("R6 restart write count", wrCount - w0, 1);
    chk("R6 restart write data", {lastAddr, lastData}, {5'h02, 8'h5A});

    // R7 data parity error, then R10 stickiness with an unused write
    clearErr(); w0 = wrCount;
    doWrite(MY, 5'h01, 8'hC3, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk("R7 data parity flag", errFlags, 7'h08);
    chk("R7 no write", wrCount - w0, 0);
    doWrite(MY, 5'h07, 8'h01, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R10 sticky accumulate", errFlags, 7'h0A);
    chk("R10 address parity bit stays 0", errFlags[4], 0);
    clearErr();
    chk("R10 errClr clears", errFlags, 0);

    // R1 pulse while clock high is not a start
    w0 = wrCount;
    sclk = 1; halfWait(); mst = 1; halfWait(); mst = 0; halfWait(); sclk = 0; halfWait();
    sendFrame({MY, 3'b010, 5'h01}, 12, 1'b0);
    sendFrame({4'h0, 8'h99}, 8, 1'b0);
    park();
    repeat (4) @(negedge clk);
    chk("R1 no start while clock high", wrCount - w0, 0);
    chk("R1 no flags", errFlags, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule